// File: doc/BRIEF.md
# Two-Region Flash Erase Walker

This block turns one erase request, given as a byte start address and a byte length, into a series of single-block erase commands for a downstream command sequencer. The flash array behind it has two erase regions. The low region is made of small parameter blocks. The high region, which starts where the low one ends, is made of large main blocks. The walker first checks that the request lies inside the array and that both ends fall on a block boundary of the region holding that end. It then issues one command per block, in rising address order, and uses the block size of whichever region the current address is in.

The sequencer acknowledges each command and reports for each one whether it failed. A failure stops the walk at once. The walker reports the outcome on a two-bit status output, and that output keeps its value until the next request is taken.

Top module: `erase_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `status` is 0.
- R2: Region 0 covers bytes 0x0 to 0x1FFFF as 8 blocks of 0x4000 bytes. Region 1 starts at 0x20000 and holds 31 blocks of 0x20000 bytes, so the array ends at 0x400000. A request whose start plus length, taken without wrap, exceeds 0x400000 ends with `status` = 2 (invalid) and issues no command.
- R3: A start address that is not a multiple of the block size of its region, measured from the region base, gives `status` = 2 and issues no command.
- R4: The end address (start plus length) must be aligned to the block size of the region it lies in. An end at or above 0x20000 counts as region 1. A misaligned end gives `status` = 2 and issues no command.
- R5: A valid request issues exactly one command per block, from the start address upward. Each step adds 0x4000 while the current address is below 0x20000 and 0x20000 from there on.
- R6: `cmd_valid` stays high and `cmd_addr` stays unchanged until the cycle in which `cmd_ack` is high.
- R7: When `cmd_ack` arrives with `cmd_fail` = 1, the walker raises no further command and sets `status` to 3 (failed).
- R8: After the acknowledge of the last block with `cmd_fail` = 0, `status` becomes 1 (done) and `req_ready` returns to 1.
- R9: A length of 0 with an aligned in-range start ends with `status` = 1 and issues no command.
- R10: While a walk is in progress, `req_ready` is 0 and `req_valid` has no effect on the commands issued.
- R11: `status` reads 0 while a walk runs. Once set to 1, 2 or 3, it holds until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_start | input | ADDR_W | Byte start address of the request |
| req_len | input | ADDR_W | Byte length of the request |
| cmd_valid | output | 1 | Block erase command pending |
| cmd_addr | output | ADDR_W | Base byte address of the block to erase |
| cmd_ack | input | 1 | Sequencer finished the pending block |
| cmd_fail | input | 1 | Qualified by `cmd_ack`: the block erase failed |
| status | output | 2 | 0 running/none, 1 done, 2 invalid, 3 failed |

## Verification
The bench aims at the seam between the two regions. One walk crosses from small to large blocks; a design that kept the small step there would issue commands at 0x24000 and so on. Requests whose end is aligned only to the small size but lies in the large region, and a start of 0xFFFFFFFF whose sum wraps, catch end-of-range checks that use the wrong block size or truncate the sum. A failure injected in the middle of a walk, a long stall on one command, and a request held on the port during a walk show whether a design keeps issuing after a failure, moves the address before the acknowledge, or takes a second request mid-walk.

// File: rtl/ew_pkg.sv
package ew_pkg;
   typedef enum logic [1:0] {
      EW_NONE = 2'd0,
      EW_DONE = 2'd1,
      EW_BAD  = 2'd2,
      EW_FAIL = 2'd3
   } ew_status_e;

   typedef enum logic {
      WK_IDLE  = 1'b0,
      WK_ISSUE = 1'b1
   } ew_state_e;

   function automatic bit ew_is_pow2(input longint v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ew_region_lookup.sv
module ew_region_lookup #(
   parameter int ADDR_W    = 32,
   parameter int SMALL_BLK = 16384,
   parameter int SMALL_CNT = 8,
   parameter int BIG_BLK   = 131072
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              in_big,
   output logic [ADDR_W-1:0] blk_bytes,
   output logic              aligned
);
   localparam logic [ADDR_W-1:0] R1_BASE = ADDR_W'(longint'(SMALL_BLK) * SMALL_CNT);

   logic [ADDR_W-1:0] rel;

   generate
      if (SMALL_CNT == 0) begin : g_single
         assign in_big = 1'b1;
      end else begin : g_split
         assign in_big = (addr >= R1_BASE);
      end
   endgenerate

   always_comb begin
      rel       = in_big ? (addr - R1_BASE) : addr;
      blk_bytes = in_big ? ADDR_W'(BIG_BLK) : ADDR_W'(SMALL_BLK);
      aligned   = ((rel & (blk_bytes - 1'b1)) == '0);
   end
endmodule

// File: rtl/ew_validator.sv
module ew_validator #(
   parameter int ADDR_W    = 32,
   parameter int SMALL_BLK = 16384,
   parameter int SMALL_CNT = 8,
   parameter int BIG_BLK   = 131072,
   parameter int BIG_CNT   = 31
) (
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W-1:0] len,
   output logic [ADDR_W-1:0] end_addr,
   output logic              ok
);
   localparam logic [ADDR_W:0] TOTAL =
      (ADDR_W+1)'(longint'(SMALL_BLK) * SMALL_CNT + longint'(BIG_BLK) * BIG_CNT);

   logic [ADDR_W:0]   sum;
   logic              start_big, end_big, start_al, end_al;
   logic [ADDR_W-1:0] start_blk, end_blk;

   assign sum      = {1'b0, start} + {1'b0, len};
   assign end_addr = sum[ADDR_W-1:0];

   ew_region_lookup #(
      .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT), .BIG_BLK(BIG_BLK)
   ) u_start_map (
      .addr(start), .in_big(start_big), .blk_bytes(start_blk), .aligned(start_al)
   );

   ew_region_lookup #(
      .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT), .BIG_BLK(BIG_BLK)
   ) u_end_map (
      .addr(end_addr), .in_big(end_big), .blk_bytes(end_blk), .aligned(end_al)
   );

   assign ok = (sum <= TOTAL) && start_al && end_al;
endmodule

// File: rtl/erase_walker.sv
module erase_walker
   import ew_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SMALL_BLK = 16384,
   parameter int SMALL_CNT = 8,
   parameter int BIG_BLK   = 131072,
   parameter int BIG_CNT   = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_len,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_ack,
   input  logic              cmd_fail,
   output logic [1:0]        status
);
   localparam longint TOTAL_BYTES = longint'(SMALL_BLK) * SMALL_CNT + longint'(BIG_BLK) * BIG_CNT;

   generate
      if (!ew_is_pow2(SMALL_BLK) || !ew_is_pow2(BIG_BLK)) begin : g_bad_blk
         $error("erase_walker: block sizes must be powers of two");
      end
      if (BIG_BLK < SMALL_BLK) begin : g_bad_order
         $error("erase_walker: upper region blocks must not be smaller");
      end
      if (TOTAL_BYTES >= (longint'(1) << ADDR_W)) begin : g_bad_width
         $error("erase_walker: ADDR_W too narrow for the array");
      end
   endgenerate

   ew_state_e         state_q;
   ew_status_e        status_q;
   logic [ADDR_W-1:0] cur_q, end_q;
   logic [ADDR_W-1:0] req_end;
   logic              req_ok;
   logic              cur_big, cur_al;
   logic [ADDR_W-1:0] cur_blk, next_addr;

   ew_validator #(
      .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT),
      .BIG_BLK(BIG_BLK), .BIG_CNT(BIG_CNT)
   ) u_check (
      .start(req_start), .len(req_len), .end_addr(req_end), .ok(req_ok)
   );

   ew_region_lookup #(
      .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT), .BIG_BLK(BIG_BLK)
   ) u_step (
      .addr(cur_q), .in_big(cur_big), .blk_bytes(cur_blk), .aligned(cur_al)
   );

   assign next_addr = cur_q + cur_blk;
   assign req_ready = (state_q == WK_IDLE);
   assign cmd_valid = (state_q == WK_ISSUE);
   assign cmd_addr  = cur_q;
   assign status    = status_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         status_q <= EW_NONE;
         cur_q    <= '0;
         end_q    <= '0;
      end else begin
         case (state_q)
            WK_IDLE: begin
               if (req_valid) begin
                  if (!req_ok) begin
                     status_q <= EW_BAD;
                  end else if (req_len == '0) begin
                     status_q <= EW_DONE;
                  end else begin
                     status_q <= EW_NONE;
                     cur_q    <= req_start;
                     end_q    <= req_end;
                     state_q  <= WK_ISSUE;
                  end
               end
            end
            WK_ISSUE: begin
               if (cmd_ack) begin
                  if (cmd_fail) begin
                     status_q <= EW_FAIL;
                     state_q  <= WK_IDLE;
                  end else if (next_addr == end_q) begin
                     status_q <= EW_DONE;
                     state_q  <= WK_IDLE;
                  end else begin
                     cur_q <= next_addr;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ew_checker.sv
module ew_checker #(
   parameter int ADDR_W    = 32,
   parameter int SMALL_BLK = 16384,
   parameter int SMALL_CNT = 8,
   parameter int BIG_BLK   = 131072,
   parameter int BIG_CNT   = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              cmd_valid,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              cmd_ack,
   input logic              cmd_fail,
   input logic [1:0]        status
);
   localparam logic [ADDR_W:0] TOTAL =
      (ADDR_W+1)'(longint'(SMALL_BLK) * SMALL_CNT + longint'(BIG_BLK) * BIG_CNT);

   a_r6_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_addr));

   a_r7_stop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ack && cmd_fail |=> !cmd_valid && status == 2'd3);

   a_r10_no_accept_mid_walk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !req_ready);

   a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready && !req_valid |=> $stable(status));

   a_r11_running_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> status == 2'd0);

   a_r2_addr_in_array: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> {1'b0, cmd_addr} < TOTAL);
endmodule

bind erase_walker ew_checker #(
   .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_CNT(SMALL_CNT),
   .BIG_BLK(BIG_BLK), .BIG_CNT(BIG_CNT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack),
   .cmd_fail(cmd_fail), .status(status)
);

// File: tb/erase_walker_test.sv
module erase_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_start = '0;
   logic [31:0] req_len = '0;
   logic        cmd_valid;
   logic [31:0] cmd_addr;
   logic        cmd_ack = 1'b0;
   logic        cmd_fail = 1'b0;
   logic [1:0]  status;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   erase_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_start(req_start), .req_len(req_len), .cmd_valid(cmd_valid),
      .cmd_addr(cmd_addr), .cmd_ack(cmd_ack), .cmd_fail(cmd_fail), .status(status)
   );

   localparam int NV = 12;
   // start, length, failing command index (-1 none), expected status
   localparam logic [31:0] V_START [NV] = '{
      32'h0, 32'h1C000, 32'h0, 32'h2000, 32'h20000, 32'h18000,
      32'h3E0000, 32'h10000, 32'h3E0000, 32'h4000, 32'h4001, 32'hFFFFFFFF};
   localparam logic [31:0] V_LEN [NV] = '{
      32'h4000, 32'h24000, 32'h400000, 32'h4000, 32'h10000, 32'h8000,
      32'h40000, 32'h50000, 32'h20000, 32'h0, 32'h0, 32'h2};
   localparam int V_FAIL [NV] = '{-1, -1, -1, -1, -1, -1, -1, 2, -1, -1, -1, -1};
   localparam logic [1:0] V_ST [NV] = '{
      2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd2, 2'd3, 2'd1, 2'd1, 2'd2, 2'd2};
   localparam string V_TAG [NV] = '{
      "R5", "R5", "R2", "R3", "R4", "R4", "R2", "R7", "R8", "R9", "R3", "R2"};

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] step_of(input logic [31:0] a);
      return (a < 32'h20000) ? 32'h4000 : 32'h20000;
   endfunction

   task automatic run_req(input logic [31:0] s, input logic [31:0] l, input int fail_at,
                          input int stall, input bit poke, input logic [1:0] exp_st,
                          input string tag);
      longint      fin;
      logic [31:0] a;
      int          n;
      int          exp_n;
      fin = longint'(s) + longint'(l);
      a = s;
      exp_n = 0;
      if (exp_st != 2'd2) begin
         if (fail_at >= 0) exp_n = fail_at + 1;
         else for (longint x = s; x < fin; x += step_of(32'(x))) exp_n++;
      end
      n = 0;
      @(negedge clk);
      req_start = s; req_len = l; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int it = 0; it < 400; it++) begin
         if (cmd_valid) begin
            check(cmd_addr == a, tag, "command address", cmd_addr, a);
            check(status == 2'd0, "R11", "status during walk", status, 0);
            if (poke && n == 0) begin
               req_start = 32'h0; req_len = 32'h4000; req_valid = 1'b1;
            end
            for (int k = 0; k < stall; k++) begin
               @(negedge clk);
               check(cmd_valid && cmd_addr == a, "R6", "held command", cmd_addr, a);
               if (poke) check(!req_ready, "R10", "ready during walk", req_ready, 0);
            end
            req_valid = 1'b0;
            cmd_ack = 1'b1;
            cmd_fail = (n == fail_at);
            @(negedge clk);
            cmd_ack = 1'b0;
            cmd_fail = 1'b0;
            n++;
            a = a + step_of(a);
         end else if (req_ready) begin
            break;
         end else begin
            @(negedge clk);
         end
      end
      check(status == exp_st, tag, "final status", status, exp_st);
      check(n == exp_n, tag, "command count", n, exp_n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      check(cmd_valid == 1'b0, "R1", "cmd_valid", cmd_valid, 0);
      check(status == 2'd0, "R1", "status", status, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         run_req(V_START[i], V_LEN[i], V_FAIL[i], 0, 1'b0, V_ST[i], V_TAG[i]);

      // R6 and R10: stalled acknowledges with a competing request on the port
      run_req(32'h18000, 32'h28000, -1, 3, 1'b1, 2'd1, "R10");

      // R11: status holds while idle
      repeat (5) @(negedge clk);
      check(status == 2'd1, "R11", "status held idle", status, 1);

      // R7 failure on the first block, then a new request clears the status
      run_req(32'h20000, 32'h40000, 0, 1, 1'b0, 2'd3, "R7");
      repeat (4) @(negedge clk);
      check(status == 2'd3, "R11", "failed status held", status, 3);
      run_req(32'h0, 32'h0, -1, 0, 1'b0, 2'd1, "R9");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule